// File: doc/BRIEF.md
# Exponent-Mantissa Timed Token Bucket Shaper

This block limits the rate at which one egress queue may send packets. A bucket holds a signed count of bits. At the end of every refill interval a programmable number of 64-bit tokens is added, and the count saturates at a burst limit that is a power of two. The refill interval is a pseudo-floating value: a mantissa plus one, shifted left by an exponent, counted in base ticks of a fixed number of core clock cycles. With a 250 MHz core clock and eight cycles per tick, one tick is 32 ns.

A packet source shows the length of its head packet and watches the eligibility output. Eligibility is high while the bucket holds more than zero bits. When the packet leaves, the source pulses the send input and the length in bits is subtracted. The count may go negative, but never by more than one maximum-size packet. Configuration arrives through single-cycle writes. A write is checked first. A bad write is refused as a whole, and an error flag reports it.

Top module: `xm_token_shaper`

## Requirements
- R1: After reset the bucket level is 0, eligibility is low, the error flag is low, the refill strobe is low and the stored port credit is 1.
- R2: After an accepted write, refills occur every ((1 + mantissa) << exponent) × CLKS_PER_TICK cycles. The first refill comes that many cycles after the write edge, and `refill_stb` is high for one cycle after each refill edge.
- R3: Each refill adds increment × 64 bits. The level is capped at 512 << burst_exp bits.
- R4: `pkt_eligible` is high exactly when the bucket level is above zero.
- R5: A send while eligible subtracts the packet length × 8 bits. A length above MAX_PKT_BYTES is treated as MAX_PKT_BYTES.
- R6: A send while not eligible has no effect on the level.
- R7: A write whose burst exponent lies outside 5..25 is refused. The error flag goes high, and the stored settings, the port credit and the refill timing stay as they were.
- R8: With the credit write-enable set, a write is refused unless the credit lies in 1..112 (`split_port` low) or 1..57 (`split_port` high). An accepted write stores the credit.
- R9: With the credit write-enable clear, the credit value is neither checked nor stored.
- R10: An accepted write clears the error flag, restarts the refill interval and clamps the level down to the new cap when it is above it.
- R11: The level never falls below −MAX_PKT_BYTES × 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_exp | input | 4 | Refill interval exponent |
| cfg_mant | input | 5 | Refill interval mantissa |
| cfg_inc | input | 5 | Tokens (64 bits each) added per refill |
| cfg_bs | input | 6 | Burst exponent; cap = 512 << value bits |
| cfg_credit_we | input | 1 | Write enable for the credit value |
| cfg_credit | input | CREDIT_W | Port credit value |
| split_port | input | 1 | Selects the split-port credit range |
| cfg_err | output | 1 | High after a refused write, low after an accepted one |
| port_credit | output | CREDIT_W | Stored port credit |
| pkt_len | input | LEN_W | Head packet length in bytes |
| pkt_send | input | 1 | Packet sent this cycle |
| pkt_eligible | output | 1 | Bucket level above zero |
| bucket_level | output | LVL_W | Signed bucket level in bits |
| refill_stb | output | 1 | One-cycle pulse after each refill |

## Verification
The bench builds the shaper with two clock cycles per tick, a 64-byte maximum packet and a 7-bit length field. At these values a full interval sweep over exponents 0..3 and a range of mantissas finishes in a few thousand cycles. The smallest buckets fill within a few dozen refills, and lengths from 0 to 127 drain the bucket past zero and cover the length clamp. Every burst exponent from 0 to 63 is written, and so is every credit value from 0 to 255 in both split modes. The expected accept or refuse outcome and the expected stored state are worked out arithmetically.

// File: rtl/xms_pkg.sv
package xms_pkg;
  localparam int EXP_W  = 4;
  localparam int MANT_W = 5;
  localparam int INC_W  = 5;
  localparam int BS_W   = 6;
  localparam int TOKEN_SHIFT = 6;    // one token = 64 bits
  localparam int BASE_BITS   = 512;  // cap = BASE_BITS << bs

  typedef struct packed {
    logic [EXP_W-1:0]  exp_v;
    logic [MANT_W-1:0] mant;
    logic [INC_W-1:0]  inc;
    logic [BS_W-1:0]   bs;
  } xms_cfg_t;
endpackage

// File: rtl/xms_cfg_regs.sv
module xms_cfg_regs
  import xms_pkg::*;
#(
  parameter int CREDIT_W           = 8,
  parameter int CREDIT_MAX_UNSPLIT = 112,
  parameter int CREDIT_MAX_SPLIT   = 57,
  parameter int BS_MIN             = 5,
  parameter int BS_MAX             = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  xms_cfg_t            cfg_in,
  input  logic                credit_we,
  input  logic [CREDIT_W-1:0] credit_in,
  input  logic                split,
  output xms_cfg_t            cfg_q,
  output logic [CREDIT_W-1:0] credit_q,
  output logic                err_q,
  output logic                accept
);
  logic                bs_ok, cred_ok;
  logic [CREDIT_W-1:0] lim;

  always_comb begin
    lim     = split ? CREDIT_W'(CREDIT_MAX_SPLIT) : CREDIT_W'(CREDIT_MAX_UNSPLIT);
    bs_ok   = (cfg_in.bs >= BS_W'(BS_MIN)) && (cfg_in.bs <= BS_W'(BS_MAX));
    cred_ok = !credit_we || ((credit_in != '0) && (credit_in <= lim));
    accept  = wr && bs_ok && cred_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '{exp_v: '0, mant: '0, inc: '0, bs: BS_W'(BS_MIN)};
      credit_q <= CREDIT_W'(1);
      err_q    <= 1'b0;
    end else if (wr) begin
      err_q <= !accept;
      if (accept) begin
        cfg_q <= cfg_in;
        if (credit_we) credit_q <= credit_in;
      end
    end
  end
endmodule

// File: rtl/xms_tick_gen.sv
module xms_tick_gen
  import xms_pkg::*;
#(
  parameter int CLKS_PER_TICK = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  output logic              refill
);
  localparam int PER_W = MANT_W + (1 << EXP_W);

  logic             tick;
  logic [PER_W-1:0] period_ticks, icnt;

  generate
    if (CLKS_PER_TICK <= 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PRE_W = $clog2(CLKS_PER_TICK);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || restart)    pre <= '0;
        else if (pre == PRE_LAST) pre <= '0;
        else                   pre <= pre + 1'b1;
      end
      assign tick = (pre == PRE_LAST);
    end
  endgenerate

  assign period_ticks = (PER_W'(mant_i) + PER_W'(1)) << exp_i;

  always_ff @(posedge clk) begin
    if (rst || restart) icnt <= '0;
    else if (tick) begin
      if (icnt == period_ticks - 1'b1) icnt <= '0;
      else                             icnt <= icnt + 1'b1;
    end
  end

  assign refill = tick && (icnt == period_ticks - 1'b1) && !restart;
endmodule

// File: rtl/xms_bucket.sv
module xms_bucket #(
  parameter int LVL_W         = 36,
  parameter int LEN_W         = 14,
  parameter int MAX_PKT_BYTES = 9216
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    refill,
  input  logic signed [LVL_W-1:0] add_bits,
  input  logic signed [LVL_W-1:0] cap,
  input  logic                    clamp_en,
  input  logic signed [LVL_W-1:0] clamp_cap,
  input  logic                    send,
  input  logic [LEN_W-1:0]        len,
  output logic signed [LVL_W-1:0] level,
  output logic                    eligible
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PKT_BYTES);

  logic [LEN_W-1:0]        len_c;
  logic signed [LVL_W-1:0] debit, sum, base, nxt;

  always_comb begin
    len_c = (len > MAX_LEN) ? MAX_LEN : len;
    debit = LVL_W'(len_c) << 3;
    sum   = level + add_bits;
    if (clamp_en)    base = (level > clamp_cap) ? clamp_cap : level;
    else if (refill) base = (sum > cap) ? cap : sum;
    else             base = level;
    nxt = (send && eligible) ? base - debit : base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= '0;
      eligible <= 1'b0;
    end else begin
      level    <= nxt;
      eligible <= (nxt > 0);
    end
  end
endmodule

// File: rtl/xm_token_shaper.sv
module xm_token_shaper
  import xms_pkg::*;
#(
  parameter int CLKS_PER_TICK      = 8,
  parameter int LEN_W              = 14,
  parameter int MAX_PKT_BYTES      = 9216,
  parameter int LVL_W              = 36,
  parameter int CREDIT_W           = 8,
  parameter int CREDIT_MAX_UNSPLIT = 112,
  parameter int CREDIT_MAX_SPLIT   = 57,
  parameter int BS_MIN             = 5,
  parameter int BS_MAX             = 25
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [3:0]              cfg_exp,
  input  logic [4:0]              cfg_mant,
  input  logic [4:0]              cfg_inc,
  input  logic [5:0]              cfg_bs,
  input  logic                    cfg_credit_we,
  input  logic [CREDIT_W-1:0]     cfg_credit,
  input  logic                    split_port,
  output logic                    cfg_err,
  output logic [CREDIT_W-1:0]     port_credit,
  input  logic [LEN_W-1:0]        pkt_len,
  input  logic                    pkt_send,
  output logic                    pkt_eligible,
  output logic signed [LVL_W-1:0] bucket_level,
  output logic                    refill_stb
);
  xms_cfg_t                cfg_in, cfg_q;
  logic                    accept, refill;
  logic signed [LVL_W-1:0] cap_q, cap_new, add_bits;

  assign cfg_in = '{exp_v: cfg_exp, mant: cfg_mant, inc: cfg_inc, bs: cfg_bs};

  xms_cfg_regs #(
    .CREDIT_W(CREDIT_W), .CREDIT_MAX_UNSPLIT(CREDIT_MAX_UNSPLIT),
    .CREDIT_MAX_SPLIT(CREDIT_MAX_SPLIT), .BS_MIN(BS_MIN), .BS_MAX(BS_MAX)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .cfg_in(cfg_in),
    .credit_we(cfg_credit_we), .credit_in(cfg_credit), .split(split_port),
    .cfg_q(cfg_q), .credit_q(port_credit), .err_q(cfg_err), .accept(accept)
  );

  xms_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst(rst), .restart(accept),
    .exp_i(cfg_q.exp_v), .mant_i(cfg_q.mant), .refill(refill)
  );

  assign cap_q    = LVL_W'(BASE_BITS) << cfg_q.bs;
  assign cap_new  = LVL_W'(BASE_BITS) << cfg_bs;
  assign add_bits = LVL_W'(cfg_q.inc) << TOKEN_SHIFT;

  xms_bucket #(.LVL_W(LVL_W), .LEN_W(LEN_W), .MAX_PKT_BYTES(MAX_PKT_BYTES)) u_bkt (
    .clk(clk), .rst(rst), .refill(refill), .add_bits(add_bits), .cap(cap_q),
    .clamp_en(accept), .clamp_cap(cap_new), .send(pkt_send), .len(pkt_len),
    .level(bucket_level), .eligible(pkt_eligible)
  );

  always_ff @(posedge clk) begin
    if (rst) refill_stb <= 1'b0;
    else     refill_stb <= refill;
  end
endmodule

// File: rtl/xms_checker.sv
module xms_checker #(
  parameter int LVL_W         = 36,
  parameter int MAX_PKT_BYTES = 9216,
  parameter int CREDIT_W      = 8,
  parameter int BS_MIN        = 5,
  parameter int BS_MAX        = 25
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_wr,
  input logic [5:0]              cfg_bs,
  input logic                    cfg_credit_we,
  input logic [CREDIT_W-1:0]     port_credit,
  input logic                    cfg_err,
  input logic                    pkt_send,
  input logic                    pkt_eligible,
  input logic signed [LVL_W-1:0] bucket_level,
  input logic                    refill_stb,
  input logic [5:0]              cur_bs
);
  localparam logic signed [LVL_W-1:0] FLOOR = LVL_W'(-(MAX_PKT_BYTES * 8));
  logic signed [LVL_W-1:0] cap_c;
  assign cap_c = LVL_W'(512) << cur_bs;

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (bucket_level == 0) && !pkt_eligible && !refill_stb && !cfg_err);

  a_r3_level_within_cap: assert property (@(posedge clk) disable iff (rst)
    bucket_level <= cap_c);

  a_r11_level_floor: assert property (@(posedge clk) disable iff (rst)
    bucket_level >= FLOOR);

  a_r4_eligible_matches_level: assert property (@(posedge clk) disable iff (rst)
    pkt_eligible == (bucket_level > 0));

  a_r7_bad_bs_refused: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && ((cfg_bs < 6'(BS_MIN)) || (cfg_bs > 6'(BS_MAX)))
    |=> cfg_err && $stable(port_credit));

  a_r9_credit_kept: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && !cfg_credit_we |=> $stable(port_credit));

  a_r6_level_idle: assert property (@(posedge clk) disable iff (rst)
    !refill_stb && !$past(pkt_send && pkt_eligible) && !$past(cfg_wr)
    |-> $stable(bucket_level));
endmodule

bind xm_token_shaper xms_checker #(
  .LVL_W(LVL_W), .MAX_PKT_BYTES(MAX_PKT_BYTES), .CREDIT_W(CREDIT_W),
  .BS_MIN(BS_MIN), .BS_MAX(BS_MAX)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_bs(cfg_bs),
  .cfg_credit_we(cfg_credit_we), .port_credit(port_credit), .cfg_err(cfg_err),
  .pkt_send(pkt_send), .pkt_eligible(pkt_eligible), .bucket_level(bucket_level),
  .refill_stb(refill_stb), .cur_bs(cfg_q.bs)
);

// File: tb/sim_xm_token_shaper.sv
module sim_xm_token_shaper;
  localparam int CPT  = 2;
  localparam int MAXB = 64;
  localparam int LW   = 7;
  localparam int VW   = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_credit_we = 0, split_port = 0, pkt_send = 0;
  logic [3:0] cfg_exp = 0;
  logic [4:0] cfg_mant = 0, cfg_inc = 0;
  logic [5:0] cfg_bs = 5;
  logic [7:0] cfg_credit = 0, port_credit;
  logic [LW-1:0] pkt_len = 0;
  logic cfg_err, pkt_eligible, refill_stb;
  logic signed [VW-1:0] bucket_level;

  int vectors = 0;
  int miscompares = 0;
  longint model;

  always #10 clk = ~clk;

  xm_token_shaper #(.CLKS_PER_TICK(CPT), .LEN_W(LW), .MAX_PKT_BYTES(MAXB), .LVL_W(VW)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_exp(cfg_exp), .cfg_mant(cfg_mant),
    .cfg_inc(cfg_inc), .cfg_bs(cfg_bs), .cfg_credit_we(cfg_credit_we),
    .cfg_credit(cfg_credit), .split_port(split_port), .cfg_err(cfg_err),
    .port_credit(port_credit), .pkt_len(pkt_len), .pkt_send(pkt_send),
    .pkt_eligible(pkt_eligible), .bucket_level(bucket_level), .refill_stb(refill_stb)
  );

  task automatic chk(input string req, input longint act, input longint exp_v);
    vectors++;
    if (act !== exp_v) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // called at a negedge, returns at the following negedge
  task automatic wcfg(input int e, input int m, input int i, input int b,
                      input bit we, input int cr);
    cfg_exp = 4'(e); cfg_mant = 5'(m); cfg_inc = 5'(i); cfg_bs = 6'(b);
    cfg_credit_we = we; cfg_credit = 8'(cr); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_credit_we = 1'b0;
  endtask

  task automatic meas(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!refill_stb && n < 5000);
  endtask

  task automatic fill(input int cycles, input longint cap, input longint add);
    model = bucket_level;
    repeat (cycles) begin
      @(posedge clk); @(negedge clk);
      if (refill_stb) model = (model + add > cap) ? cap : model + add;
      chk("R3 level after refill", bucket_level, model);
    end
  endtask

  task automatic send(input int len);
    bit el;
    longint d;
    el = pkt_eligible;
    pkt_len = LW'(len); pkt_send = 1'b1;
    @(negedge clk);
    pkt_send = 1'b0;
    d = ((len > MAXB) ? MAXB : len) * 8;
    if (el) begin
      model = model - d;
      chk("R5 debit on send", bucket_level, model);
    end else begin
      chk("R6 ignored send", bucket_level, model);
    end
    chk("R4 eligible vs level", pkt_eligible, (model > 0) ? 1 : 0);
    chk("R11 floor", (bucket_level >= -(MAXB * 8)) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int mv[4] = '{0, 1, 5, 31};
    int n;
    int lim;
    longint cred_exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 level", bucket_level, 0);
    chk("R1 eligible", pkt_eligible, 0);
    chk("R1 err", cfg_err, 0);
    chk("R1 credit", port_credit, 1);
    chk("R1 strobe", refill_stb, 0);
    rst = 1'b0;

    // R2: interval sweep
    for (int e = 0; e < 4; e++) begin
      for (int k = 0; k < 4; k++) begin
        wcfg(e, mv[k], 0, 5, 0, 0);
        chk("R10 err cleared", cfg_err, 0);
        meas(n);
        chk("R2 first interval", n, CPT * ((1 + mv[k]) << e));
        meas(n);
        chk("R2 next interval", n, CPT * ((1 + mv[k]) << e));
      end
    end

    // R3: fill to 16384-bit cap
    wcfg(0, 0, 31, 5, 0, 0);
    fill(60, 16384, 31 * 64);
    chk("R3 full at cap", bucket_level, 16384);
    chk("R4 eligible when full", pkt_eligible, 1);
    wcfg(0, 0, 31, 6, 0, 0);
    fill(60, 32768, 31 * 64);
    chk("R3 full at larger cap", bucket_level, 32768);
    // R10: clamp to smaller cap
    wcfg(0, 0, 0, 5, 0, 0);
    chk("R10 clamp to new cap", bucket_level, 16384);

    // R5/R6/R11: length sweep drains the bucket
    model = 16384;
    for (int l = 0; l < 128; l++) send(l);

    // R7: burst exponent sweep
    wcfg(0, 3, 0, 5, 1, 10);
    chk("R8 credit stored", port_credit, 10);
    for (int b = 0; b < 64; b++) begin
      wcfg(0, 3, 0, b, 0, 0);
      chk("R7 err flag", cfg_err, (b < 5 || b > 25) ? 1 : 0);
      chk("R7 credit kept", port_credit, 10);
    end
    wcfg(0, 0, 0, 26, 0, 0);
    chk("R7 refused err", cfg_err, 1);
    meas(n);
    meas(n);
    chk("R7 interval unchanged", n, CPT * 4);

    // R8/R9: credit sweep in both split modes
    cred_exp = port_credit;
    for (int s = 0; s < 2; s++) begin
      split_port = s[0];
      lim = s ? 57 : 112;
      for (int c = 0; c < 256; c++) begin
        wcfg(0, 0, 0, 5, 1, c);
        if (c >= 1 && c <= lim) cred_exp = c;
        chk("R8 err", cfg_err, (c >= 1 && c <= lim) ? 0 : 1);
        chk("R8 credit", port_credit, cred_exp);
      end
      wcfg(0, 0, 0, 5, 0, 200);
      chk("R9 err", cfg_err, 0);
      chk("R9 credit kept", port_credit, cred_exp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule